// File: doc/BRIEF.md
# Prescaled 64-bit Global Tick Counter

This block holds one 64-bit up-counter shared by every processor in a cluster. It advances at a programmable fraction of the input clock and exports its value to the per-processor compare units. Software sees it through a small register window of 32-bit words. The window holds the counter's two halves and a shared control word. The control word carries the run bit, an 8-bit divide value and three bits that are only forwarded to the compare units.

While the run bit is set, the counter steps once every (divide+1) clock cycles. The divider restarts each time the run bit goes from clear to set. Software loads the counter one half at a time, and only while it is stopped. A load issued while the counter runs is discarded without notice. The bus port is a plain single-cycle request: valid, write flag, byte address and write data. Read data is registered and appears on the cycle after the request.

Top module: `gtick_top`

## Requirements
- R1: A synchronous active-low reset clears the counter, the run bit, the divide value and the forwarded bits. Reads afterwards return zero for both counter words and for the control word.
- R2: Word offset 0x00 holds counter bits 31:0 and offset 0x04 holds bits 63:32. A read returns the current half on `bus_rdata` one cycle after the request. `count_value` always shows the full counter.
- R3: The control word is at offset 0x08. Bit 0 is the run bit, bits 3:1 are forwarded on `cmp_ctrl`, and bits 15:8 are the divide value. All other bits read as zero, and the fields change only on a control write.
- R4: With the run bit set and divide value P, the counter steps by one on every (P+1)-th clock edge. The first step falls P+1 edges after the write that set the run bit.
- R5: With the run bit clear, the counter holds its value.
- R6: A write to either counter word while the run bit is set leaves the counter unchanged apart from its normal stepping.
- R7: A write to a counter word while the run bit is clear replaces that 32-bit half on the next edge and leaves the other half unchanged.
- R8: Stepping carries from bit 31 into bit 32, and the counter wraps from all ones to zero.
- R9: Aligned offsets 0x0C to 0x1C read as zero, and writes to them change no state.
- R10: An access whose address bits 1:0 are not zero is not a word access. It reads as zero and its writes change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address in the 0x20 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| count_value | output | 64 | Current counter value, to the compare units |
| timer_en | output | 1 | Run bit |
| cmp_ctrl | output | 3 | Forwarded control bits 3:1 |

## Verification
The stepping is swept over the divide values 0, 1, 2, 3, 4, 7, 15 and 255, and the counter is compared on every cycle with start + floor(k/(P+1)). This separates an off-by-one in the divider from a wrong restart point after enabling. Start values just below the 32-bit boundary and just below the 64-bit boundary tell a correct carry and wrap apart from a split or truncated adder. Separate patterns cover four cases:
- counter loads while running and while stopped, which tell a dropped write from a one-half or a both-halves overwrite;
- control writes with all bits set, which expose unmasked reserved bits;
- accesses to unmapped offsets;
- misaligned accesses, which must leave every piece of state as it was.

// File: rtl/gtick_pkg.sv
`timescale 1ns/1ps
// Package: gtick_pkg
// Shared word indices and control-field positions of the tick counter window.
// Assumes 32-bit word access; indices are byte offset divided by four.
package gtick_pkg;
    localparam int unsigned WIDX_CNT_LO = 0;
    localparam int unsigned WIDX_CNT_HI = 1;
    localparam int unsigned WIDX_CTRL   = 2;
    localparam int unsigned EN_POS      = 0;
    localparam int unsigned CMP_LSB     = 1;
    localparam int unsigned PRE_LSB     = 8;
endpackage

// File: rtl/gtick_regif.sv
`timescale 1ns/1ps
// Module: gtick_regif
// Decodes the register window and holds the shared control fields.
// Produces the gated counter-load strobes and the registered read data.
// Assumes a single-cycle request; accesses with addr[1:0] != 0 are ignored.
module gtick_regif
    import gtick_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned PRE_W  = 8,
    parameter int unsigned CMP_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [2*DATA_W-1:0]   cnt_i,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  en_o,
    output logic [CMP_W-1:0]      cmp_o,
    output logic [PRE_W-1:0]      pre_o,
    output logic                  wr_lo_o,
    output logic                  wr_hi_o
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic              aligned;
    logic [WORD_W-1:0] word_idx;
    logic              acc;
    logic              hit_lo, hit_hi, hit_ctrl;
    logic              en_q;
    logic [CMP_W-1:0]  cmp_q;
    logic [PRE_W-1:0]  pre_q;
    logic [DATA_W-1:0] ctrl_img;
    logic [DATA_W-1:0] rd_mux;

    // Address decode: only word-aligned requests reach a register.
    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        word_idx = bus_addr[ADDR_W-1:2];
        acc      = bus_valid && aligned;
        hit_lo   = acc && (word_idx == WORD_W'(WIDX_CNT_LO));
        hit_hi   = acc && (word_idx == WORD_W'(WIDX_CNT_HI));
        hit_ctrl = acc && (word_idx == WORD_W'(WIDX_CTRL));
    end

    // Control fields: loaded only by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cmp_q <= '0;
            pre_q <= '0;
        end else if (hit_ctrl && bus_write) begin
            en_q  <= bus_wdata[EN_POS];
            cmp_q <= bus_wdata[CMP_LSB +: CMP_W];
            pre_q <= bus_wdata[PRE_LSB +: PRE_W];
        end
    end

    // Control read image: unused bits read as zero.
    always_comb begin
        ctrl_img                    = '0;
        ctrl_img[EN_POS]            = en_q;
        ctrl_img[CMP_LSB +: CMP_W]  = cmp_q;
        ctrl_img[PRE_LSB +: PRE_W]  = pre_q;
    end

    // Read multiplexer: unmapped or misaligned offsets give zero.
    always_comb begin
        rd_mux = '0;
        if (hit_lo)        rd_mux = cnt_i[DATA_W-1:0];
        else if (hit_hi)   rd_mux = cnt_i[2*DATA_W-1:DATA_W];
        else if (hit_ctrl) rd_mux = ctrl_img;
    end

    // Read data register: updated on every read request.
    always_ff @(posedge clk) begin
        if (!rst_n)                      bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
    end

    // Counter-load strobes: suppressed while the counter runs.
    assign wr_lo_o = hit_lo && bus_write && !en_q;
    assign wr_hi_o = hit_hi && bus_write && !en_q;
    assign en_o    = en_q;
    assign cmp_o   = cmp_q;
    assign pre_o   = pre_q;
endmodule

// File: rtl/gtick_prescale.sv
`timescale 1ns/1ps
// Module: gtick_prescale
// Divide-by-(P+1) step generator. The divider is held at zero while stopped,
// so it restarts on every enable and the first step comes P+1 edges later.
// Assumes P may change while running; a divider past P wraps at once.
module gtick_prescale #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] div_q;

    // Step request: divider has reached the divide value.
    assign tick_o = en_i && (div_q >= pre_i);

    // Divider: cleared while stopped and after each step.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) div_q <= '0;
        else if (tick_o)     div_q <= '0;
        else                 div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/gtick_count64.sv
`timescale 1ns/1ps
// Module: gtick_count64
// Counter built from two halves. A half is loaded from the bus when its strobe
// is set, otherwise it takes its slice of the incremented value.
// Assumes load strobes and step are never active together (regif gates them).
module gtick_count64 #(
    parameter int unsigned HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [HALF_W-1:0]   wdata_i,
    output logic [2*HALF_W-1:0] cnt_o
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [1:0]       wr_half;

    assign wr_half = {wr_hi_i, wr_lo_i};
    assign cnt_inc = cnt_q + CNT_W'(tick_i);

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] half_q;
        // Half register: bus load has priority over the step value.
        always_ff @(posedge clk) begin
            if (!rst_n)          half_q <= '0;
            else if (wr_half[h]) half_q <= wdata_i;
            else                 half_q <= cnt_inc[h*HALF_W +: HALF_W];
        end
        assign cnt_q[h*HALF_W +: HALF_W] = half_q;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/gtick_top.sv
`timescale 1ns/1ps
// Module: gtick_top
// Shared 64-bit tick counter with a 32-bit register window of 0x20 bytes.
// Assumes ADDR_W = 5, DATA_W = 32, and PRE_W + 8 <= DATA_W.
module gtick_top #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned PRE_W  = 8,
    parameter int unsigned CMP_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [2*DATA_W-1:0] count_value,
    output logic                timer_en,
    output logic [CMP_W-1:0]    cmp_ctrl
);
    logic             en_w;
    logic [PRE_W-1:0] pre_w;
    logic             wr_lo_w, wr_hi_w;
    logic             cnt_tick;

    gtick_regif #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W), .CMP_W(CMP_W)
    ) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cnt_i(count_value), .bus_rdata(bus_rdata),
        .en_o(en_w), .cmp_o(cmp_ctrl), .pre_o(pre_w),
        .wr_lo_o(wr_lo_w), .wr_hi_o(wr_hi_w)
    );

    gtick_prescale #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .en_i(en_w), .pre_i(pre_w), .tick_o(cnt_tick)
    );

    gtick_count64 #(.HALF_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(cnt_tick),
        .wr_lo_i(wr_lo_w), .wr_hi_i(wr_hi_w), .wdata_i(bus_wdata),
        .cnt_o(count_value)
    );

    assign timer_en = en_w;
endmodule

// File: rtl/gtick_checker.sv
`timescale 1ns/1ps
// Module: gtick_checker
// Temporal checks on the tick counter, bound into gtick_top.
module gtick_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CMP_W  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [2*DATA_W-1:0] count_value,
    input logic                timer_en,
    input logic [CMP_W-1:0]    cmp_ctrl,
    input logic                tick
);
    logic wr_lo, wr_hi, wr_ctrl;
    assign wr_lo   = bus_valid && bus_write && (bus_addr == ADDR_W'(0));
    assign wr_hi   = bus_valid && bus_write && (bus_addr == ADDR_W'(4));
    assign wr_ctrl = bus_valid && bus_write && (bus_addr == ADDR_W'(8));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (count_value == '0 && !timer_en && cmp_ctrl == '0));

    // R4
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count_value == $past(count_value) + 1'b1));

    // R5
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_en && !wr_lo && !wr_hi) |=> $stable(count_value));

    // R6
    drop_running_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_en && (wr_lo || wr_hi)) |=> ((count_value - $past(count_value)) <= 1));

    // R7
    load_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_en && wr_lo) |=> (count_value[DATA_W-1:0] == $past(bus_wdata)
            && $stable(count_value[2*DATA_W-1:DATA_W])));

    // R3
    ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> ($stable(timer_en) && $stable(cmp_ctrl)));

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count_value)) |=> (count_value == '0));
endmodule

bind gtick_top gtick_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count_value(count_value),
    .timer_en(timer_en), .cmp_ctrl(cmp_ctrl), .tick(cnt_tick)
);

// File: tb/gtick_top_bench.sv
`timescale 1ns/1ps
// Bench for gtick_top: per-cycle sweeps of the divide value plus register cases.
module gtick_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] count_value;
    logic        timer_en;
    logic [2:0]  cmp_ctrl;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gtick_top u_gtick_top (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count_value(count_value), .timer_en(timer_en), .cmp_ctrl(cmp_ctrl)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; the write lands on the rising edge between.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic sweep(input int p, input logic [63:0] start);
        int n;
        logic [31:0] r;
        logic [63:0] fin;
        n = 3 * (p + 1) + 2;
        wr(5'h00, start[31:0]);
        wr(5'h04, start[63:32]);
        wr(5'h08, (32'(p) << 8) | 32'h1);
        for (int k = 0; k <= n; k++) begin
            chk("R4/R8 step", count_value, start + 64'(k / (p + 1)));
            @(negedge clk);
        end
        wr(5'h08, 32'(p) << 8);
        fin = start + 64'((n + 2) / (p + 1));
        chk("R4 count at stop", count_value, fin);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R5 hold", count_value, fin);
        end
        rd(5'h00, r); chk("R2 low word", 64'(r), 64'(fin[31:0]));
        rd(5'h04, r); chk("R2 high word", 64'(r), 64'(fin[63:32]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        int plist [8] = '{0, 1, 2, 3, 4, 7, 15, 255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 count", count_value, 64'h0);
        chk("R1 enable", 64'(timer_en), 64'h0);
        chk("R1 cmp", 64'(cmp_ctrl), 64'h0);
        rd(5'h08, r); chk("R1 ctrl read", 64'(r), 64'h0);
        rd(5'h04, r); chk("R1 high read", 64'(r), 64'h0);

        // R4 R5 R2 sweep over divide values
        foreach (plist[i]) sweep(plist[i], 64'h0000_0100_0000_0020 + 64'(i));
        // R8 carry across halves and full wrap
        sweep(0, 64'h0000_0007_FFFF_FFFE);
        chk("R8 carry high", count_value[63:32], 64'h8);
        sweep(1, 64'hFFFF_FFFF_FFFF_FFFE);

        // R7 half replacement while stopped
        wr(5'h00, 32'h1111_2222);
        wr(5'h04, 32'h3333_4444);
        chk("R7 both halves", count_value, 64'h3333_4444_1111_2222);
        wr(5'h00, 32'hAAAA_5555);
        chk("R7 low only", count_value, 64'h3333_4444_AAAA_5555);
        wr(5'h04, 32'h0BAD_F00D);
        chk("R7 high only", count_value, 64'h0BAD_F00D_AAAA_5555);

        // R6 loads dropped while running (divide 255 so no step happens here)
        wr(5'h00, 32'h100); wr(5'h04, 32'h0);
        wr(5'h08, 32'h0000_FF01);
        wr(5'h00, 32'hDEAD_BEEF);
        wr(5'h04, 32'hCAFE_F00D);
        chk("R6 running load dropped", count_value, 64'h100);
        rd(5'h00, r); chk("R6 low readback", 64'(r), 64'h100);
        wr(5'h08, 32'h0);

        // R3 control fields and masking
        wr(5'h08, 32'hFFFF_FFFE);
        rd(5'h08, r); chk("R3 ctrl mask", 64'(r), 64'h0000_FF0E);
        chk("R3 cmp out", 64'(cmp_ctrl), 64'h7);
        chk("R3 enable off", 64'(timer_en), 64'h0);
        wr(5'h08, 32'h0000_0305);
        chk("R3 cmp out 2", 64'(cmp_ctrl), 64'h2);
        chk("R3 enable on", 64'(timer_en), 64'h1);
        wr(5'h08, 32'h0);
        wr(5'h00, 32'h0000_1234); wr(5'h04, 32'h0000_0055);

        // R9 unmapped offsets: zero reads, writes with no effect
        for (int a = 12; a < 32; a += 4) begin
            rd(5'h00, r);
            rd(5'(a), r); chk("R9 unmapped read", 64'(r), 64'h0);
            wr(5'(a), 32'hFFFF_FFFF);
        end
        chk("R9 count kept", count_value, 64'h0000_0055_0000_1234);
        rd(5'h08, r); chk("R9 ctrl kept", 64'(r), 64'h0);

        // R10 misaligned accesses
        wr(5'h09, 32'h0000_0001);
        chk("R10 no enable", 64'(timer_en), 64'h0);
        wr(5'h01, 32'h9999_9999);
        wr(5'h06, 32'h9999_9999);
        chk("R10 count kept", count_value, 64'h0000_0055_0000_1234);
        rd(5'h00, r);
        rd(5'h01, r); chk("R10 misaligned read", 64'(r), 64'h0);

        // R1 reset while running
        wr(5'h08, 32'h0000_0001);
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 run reset count", count_value, 64'h0);
        chk("R1 run reset enable", 64'(timer_en), 64'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule